// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error, Idle and Wake-Up Handling

This block recovers asynchronous serial characters from a single input line. It is clocked by the system clock and advanced by a sixteen-times-bit-rate enable pulse supplied from outside. A falling edge while the line is quiet starts a frame. Each bit is then judged by a two-out-of-three vote over the samples around its middle. Eight or nine data bits arrive least significant first. At the middle of the stop bit the finished character is moved into a holding register that software reads.

The receiver reports status alongside the character: data-full, overrun, noise, framing error and idle line. It raises a receive interrupt and an idle interrupt, each behind its own enable. Software clears the data-full and error flags with a status access followed by a data access. A sleep control lets the receiver ignore traffic meant for other listeners. It wakes either on an idle line or on a character whose top data bit is set.

Top module: `serial_rx_core`

## Requirements
- R1: After reset all flags, both interrupt outputs, the sleep indication and the 9-bit character output are 0.
- R2: Data bits are taken least significant first. In 8-bit mode (nineBit=0) the character appears on rxData[7:0] with rxData[8]=0. In 9-bit mode all nine bits are used. The character and fullFlag update at the middle of the stop bit.
- R3: Each bit value is the majority of the samples at oversample phases 7, 8 and 9, counted from 0 at the tick that first sees the start bit low. noiseFlag is set with the character if the three samples of any bit in the frame disagree.
- R4: frameErrFlag is set with the character when the voted stop bit is 0.
- R5: A character that completes while fullFlag is 1 sets overrunFlag and is dropped; rxData keeps the earlier character.
- R6: A dataRead pulse clears fullFlag, overrunFlag, noiseFlag, frameErrFlag and idleFlag only if a statusRead pulse came before it with no dataRead in between. A dataRead alone changes nothing.
- R7: rxIrq is 1 exactly when rieEn is 1 and fullFlag or overrunFlag is 1.
- R8: A start bit whose mid-bit vote is 1 is rejected, and no character or flag results.
- R9: idleFlag sets after the line has been sampled high for one frame time: 160 ticks in 8-bit mode, 176 in 9-bit mode. It sets only if a character has been accepted since idleFlag last set, and only while the receiver is awake.
- R10: idleIrq is 1 exactly when ilieEn is 1 and idleFlag is 1.
- R11: A wakeSet pulse sets asleep. While asleep, characters do not set fullFlag. With wakeSel=0, one frame time of high line clears asleep without setting idleFlag.
- R12: With wakeSel=1, a character whose top data bit is 1 clears asleep and is received normally. A character with that bit 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rxEnable | input | 1 | Receiver enable; 0 holds the framer in hunt |
| nineBit | input | 1 | 1 selects nine data bits, 0 selects eight |
| wakeSel | input | 1 | Wake method: 0 idle line, 1 top data bit set |
| wakeSet | input | 1 | Pulse that puts the receiver to sleep |
| statusRead | input | 1 | Pulse marking a status register access |
| dataRead | input | 1 | Pulse marking a data register access |
| rieEn | input | 1 | Receive interrupt enable |
| ilieEn | input | 1 | Idle interrupt enable |
| rxData | output | 9 | Last accepted character |
| fullFlag | output | 1 | Character waiting |
| overrunFlag | output | 1 | Character lost |
| noiseFlag | output | 1 | Sample disagreement in accepted frame |
| frameErrFlag | output | 1 | Stop bit sampled low |
| idleFlag | output | 1 | Idle line seen |
| asleep | output | 1 | Receiver in sleep mode |
| rxIrq | output | 1 | Receive interrupt request |
| idleIrq | output | 1 | Idle interrupt request |

## Verification
The bench attacks the corners where a receiver silently corrupts state. It sends a second character before the first is read; a design that overwrote the holding register would show the new byte instead of the old one. It sends a single flipped sample at mid-bit; a design that votes wrongly would corrupt the data, and one that ignores disagreement would leave noise clear. It also sends a dataRead without a preceding statusRead, which a lax design would treat as a clear. For idle, the bench waits through long quiet spells before any character and again after a clear. A design that armed idle unconditionally would raise the flag there. The bench also checks both wake methods, including an address-mode character with its top bit clear that must stay invisible.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef struct packed {
    logic startFrame;
    logic inFrame;
    logic shiftBit;
    logic loadData;
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_MAX    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tick,
  input  logic                        enable,
  input  logic                        rxd,
  input  logic                        nineBit,
  input  rxStrobe_t                   strobe,
  output logic [$clog2(OVS)-1:0]      phase,
  output logic                        sampleNow,
  output logic                        vote,
  output logic                        disagree,
  output logic                        charMsb,
  output logic                        idleLine,
  output logic [DATA_MAX-1:0]         rxData
);
  localparam int PHASE_W = $clog2(OVS);
  localparam int IDLE_W  = $clog2(OVS * (DATA_MAX + 2) + 1);
  localparam logic [IDLE_W-1:0] FRAME_LONG  = IDLE_W'(OVS * (DATA_MAX + 2));
  localparam logic [IDLE_W-1:0] FRAME_SHORT = IDLE_W'(OVS * (DATA_MAX + 1));

  logic [SYNC_STAGES-1:0] syncQ;
  logic [1:0]             hist;
  logic [2:0]             trio;
  logic [DATA_MAX-1:0]    shiftReg;
  logic [DATA_MAX-1:0]    charNow;
  logic [IDLE_W-1:0]      highRun;
  logic [IDLE_W-1:0]      frameTicks;
  logic                   stepEn;

  // input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxd};
  end
  assign sampleNow = syncQ[SYNC_STAGES-1];
  assign stepEn    = tick & enable;

  // three-sample window and vote
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       hist <= 2'b11;
    else if (stepEn) hist <= {hist[0], sampleNow};
  end
  assign trio     = {hist, sampleNow};
  assign vote     = (trio[0] & trio[1]) | (trio[0] & trio[2]) | (trio[1] & trio[2]);
  assign disagree = (trio != 3'b000) && (trio != 3'b111);

  // oversample phase within the current bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   phase <= '0;
    else if (!enable)            phase <= '0;
    else if (strobe.startFrame)  phase <= PHASE_W'(1);
    else if (tick) begin
      if (strobe.inFrame) phase <= phase + 1'b1;
      else                phase <= '0;
    end
  end

  // character assembly, LSB first into the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobe.shiftBit) shiftReg <= {vote, shiftReg[DATA_MAX-1:1]};
  end
  assign charNow = nineBit ? shiftReg : {1'b0, shiftReg[DATA_MAX-1:1]};
  assign charMsb = shiftReg[DATA_MAX-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rxData <= '0;
    else if (strobe.loadData) rxData <= charNow;
  end

  // run of high samples for idle-line detection
  assign frameTicks = nineBit ? FRAME_LONG : FRAME_SHORT;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        highRun <= '0;
    else if (!enable) highRun <= '0;
    else if (tick) begin
      if (!sampleNow)               highRun <= '0;
      else if (highRun != frameTicks) highRun <= highRun + 1'b1;
    end
  end
  assign idleLine = stepEn & sampleNow & (highRun == frameTicks - 1'b1);
endmodule

// File: rtl/serial_rx_control.sv
module serial_rx_control
  import serial_rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DATA_MAX = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic                   enable,
  input  logic                   nineBit,
  input  logic                   wakeSel,
  input  logic                   wakeSet,
  input  logic                   statusRead,
  input  logic                   dataRead,
  input  logic [$clog2(OVS)-1:0] phase,
  input  logic                   sampleNow,
  input  logic                   vote,
  input  logic                   disagree,
  input  logic                   charMsb,
  input  logic                   idleLine,
  output rxStrobe_t              strobe,
  output logic                   fullFlag,
  output logic                   overrunFlag,
  output logic                   noiseFlag,
  output logic                   frameErrFlag,
  output logic                   idleFlag,
  output logic                   asleep
);
  localparam int PHASE_W = $clog2(OVS);
  localparam int IDX_W   = $clog2(DATA_MAX + 2);
  localparam logic [PHASE_W-1:0] MID_PHASE  = PHASE_W'(OVS / 2 + 1);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(OVS - 1);
  localparam logic [IDX_W-1:0]   IDX_LONG   = IDX_W'(DATA_MAX + 1);
  localparam logic [IDX_W-1:0]   IDX_SHORT  = IDX_W'(DATA_MAX);

  logic             inFrame;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             noiseAcc;
  logic             statusSeen;
  logic             idleArmed;
  logic             stepEn, midTick, endTick;
  logic             startFrame, falseStart, frameDone, accept, loadData;
  logic             clearSeq, idleSet, wakeNow;

  assign stepEn     = tick & enable;
  assign lastIdx    = nineBit ? IDX_LONG : IDX_SHORT;
  assign midTick    = stepEn & inFrame & (phase == MID_PHASE);
  assign endTick    = stepEn & inFrame & (phase == LAST_PHASE);
  assign startFrame = stepEn & ~inFrame & ~sampleNow;
  assign falseStart = midTick & (bitIdx == '0) & vote;
  assign frameDone  = midTick & (bitIdx == lastIdx);
  assign accept     = frameDone & (~asleep | (wakeSel & charMsb));
  assign loadData   = accept & ~fullFlag;
  assign clearSeq   = dataRead & statusSeen;
  assign idleSet    = idleLine & ~asleep & idleArmed;
  assign wakeNow    = asleep & ((idleLine & ~wakeSel) | (frameDone & wakeSel & charMsb));

  assign strobe.startFrame = startFrame;
  assign strobe.inFrame    = inFrame;
  assign strobe.shiftBit   = midTick & (bitIdx != '0) & (bitIdx != lastIdx);
  assign strobe.loadData   = loadData;

  // frame sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      bitIdx  <= '0;
    end else if (!enable) begin
      inFrame <= 1'b0;
      bitIdx  <= '0;
    end else if (startFrame) begin
      inFrame <= 1'b1;
      bitIdx  <= '0;
    end else if (falseStart || frameDone) begin
      inFrame <= 1'b0;
    end else if (endTick) begin
      bitIdx <= bitIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           noiseAcc <= 1'b0;
    else if (startFrame) noiseAcc <= 1'b0;
    else if (midTick)    noiseAcc <= noiseAcc | disagree;
  end

  // status-then-data clear handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           statusSeen <= 1'b0;
    else if (statusRead) statusSeen <= 1'b1;
    else if (dataRead)   statusSeen <= 1'b0;
  end

  // receive flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullFlag     <= 1'b0;
      noiseFlag    <= 1'b0;
      frameErrFlag <= 1'b0;
      overrunFlag  <= 1'b0;
    end else begin
      if (loadData) begin
        fullFlag     <= 1'b1;
        noiseFlag    <= noiseAcc | disagree;
        frameErrFlag <= ~vote;
      end else if (clearSeq) begin
        fullFlag     <= 1'b0;
        noiseFlag    <= 1'b0;
        frameErrFlag <= 1'b0;
      end
      if (accept && fullFlag) overrunFlag <= 1'b1;
      else if (clearSeq)      overrunFlag <= 1'b0;
    end
  end

  // idle detection armed by an accepted character
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleArmed <= 1'b0;
      idleFlag  <= 1'b0;
    end else begin
      if (accept)       idleArmed <= 1'b1;
      else if (idleSet) idleArmed <= 1'b0;
      if (idleSet)       idleFlag <= 1'b1;
      else if (clearSeq) idleFlag <= 1'b0;
    end
  end

  // sleep control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        asleep <= 1'b0;
    else if (wakeSet) asleep <= 1'b1;
    else if (wakeNow) asleep <= 1'b0;
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_MAX    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick16,
  input  logic                rxd,
  input  logic                rxEnable,
  input  logic                nineBit,
  input  logic                wakeSel,
  input  logic                wakeSet,
  input  logic                statusRead,
  input  logic                dataRead,
  input  logic                rieEn,
  input  logic                ilieEn,
  output logic [DATA_MAX-1:0] rxData,
  output logic                fullFlag,
  output logic                overrunFlag,
  output logic                noiseFlag,
  output logic                frameErrFlag,
  output logic                idleFlag,
  output logic                asleep,
  output logic                rxIrq,
  output logic                idleIrq
);
  rxStrobe_t              strobe;
  logic [$clog2(OVS)-1:0] phase;
  logic sampleNow, vote, disagree, charMsb, idleLine;

  serial_rx_datapath #(.OVS(OVS), .DATA_MAX(DATA_MAX), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick16), .enable(rxEnable), .rxd(rxd),
    .nineBit(nineBit), .strobe(strobe), .phase(phase), .sampleNow(sampleNow),
    .vote(vote), .disagree(disagree), .charMsb(charMsb), .idleLine(idleLine),
    .rxData(rxData)
  );

  serial_rx_control #(.OVS(OVS), .DATA_MAX(DATA_MAX)) ctl_i (
    .clk(clk), .rstN(rstN), .tick(tick16), .enable(rxEnable), .nineBit(nineBit),
    .wakeSel(wakeSel), .wakeSet(wakeSet), .statusRead(statusRead), .dataRead(dataRead),
    .phase(phase), .sampleNow(sampleNow), .vote(vote), .disagree(disagree),
    .charMsb(charMsb), .idleLine(idleLine), .strobe(strobe), .fullFlag(fullFlag),
    .overrunFlag(overrunFlag), .noiseFlag(noiseFlag), .frameErrFlag(frameErrFlag),
    .idleFlag(idleFlag), .asleep(asleep)
  );

  assign rxIrq   = rieEn & (fullFlag | overrunFlag);
  assign idleIrq = ilieEn & idleFlag;
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
  parameter int DATA_MAX = 9
) (
  input logic                clk,
  input logic                rstN,
  input logic [DATA_MAX-1:0] rxData,
  input logic                fullFlag,
  input logic                overrunFlag,
  input logic                noiseFlag,
  input logic                frameErrFlag,
  input logic                idleFlag,
  input logic                asleep,
  input logic                idleIrq
);
  p_data_with_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> $rose(fullFlag));

  p_noise_with_char_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(noiseFlag) |-> fullFlag);

  p_frame_err_with_char_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErrFlag) |-> fullFlag);

  p_overrun_keeps_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> $stable(rxData));

  p_idle_only_awake_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleFlag) |-> !$past(asleep));

  p_idle_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    idleIrq |-> idleFlag);

  p_no_full_while_asleep_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> !asleep);
endmodule

bind serial_rx_core serial_rx_core_chk #(.DATA_MAX(DATA_MAX)) chk_i (
  .clk(clk), .rstN(rstN), .rxData(rxData), .fullFlag(fullFlag),
  .overrunFlag(overrunFlag), .noiseFlag(noiseFlag), .frameErrFlag(frameErrFlag),
  .idleFlag(idleFlag), .asleep(asleep), .idleIrq(idleIrq)
);

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0, rxd = 1'b1, rxEnable = 1'b1, nineBit = 1'b0;
  logic wakeSel = 1'b0, wakeSet = 1'b0, statusRead = 1'b0, dataRead = 1'b0;
  logic rieEn = 1'b0, ilieEn = 1'b0;
  logic [8:0] rxData;
  logic fullFlag, overrunFlag, noiseFlag, frameErrFlag, idleFlag, asleep, rxIrq, idleIrq;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  serial_rx_core dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxd(rxd), .rxEnable(rxEnable),
    .nineBit(nineBit), .wakeSel(wakeSel), .wakeSet(wakeSet), .statusRead(statusRead),
    .dataRead(dataRead), .rieEn(rieEn), .ilieEn(ilieEn), .rxData(rxData),
    .fullFlag(fullFlag), .overrunFlag(overrunFlag), .noiseFlag(noiseFlag),
    .frameErrFlag(frameErrFlag), .idleFlag(idleFlag), .asleep(asleep),
    .rxIrq(rxIrq), .idleIrq(idleIrq)
  );

  // {nineBit, data[8:0], noisy, badStop}
  localparam logic [11:0] VEC [6] = '{
    {1'b0, 9'h0A5, 1'b0, 1'b0},
    {1'b0, 9'h03C, 1'b1, 1'b0},
    {1'b1, 9'h1C3, 1'b0, 1'b0},
    {1'b0, 9'h000, 1'b0, 1'b1},
    {1'b1, 9'h0FF, 1'b1, 1'b1},
    {1'b0, 9'h1FF, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic oneTick();
    repeat (3) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) oneTick();
  endtask

  task automatic sendBit(input logic v, input logic noisy);
    for (int t = 0; t < 16; t++) begin
      rxd = (noisy && t == 8) ? ~v : v;
      oneTick();
    end
    rxd = v;
  endtask

  task automatic sendFrame(input logic nine, input logic [8:0] d, input logic noisy,
                           input logic badStop);
    sendBit(1'b0, 1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) sendBit(d[i], noisy && i == 2);
    if (badStop) begin
      rxd = 1'b0;
      ticks(10);
      rxd = 1'b1;
      ticks(6);
    end else begin
      sendBit(1'b1, 1'b0);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic clearFlags();
    pulse(statusRead);
    pulse(dataRead);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rxData", 16'(rxData), 16'h0);
    check("R1 flags", {11'b0, fullFlag, overrunFlag, noiseFlag, frameErrFlag, idleFlag}, 16'h0);
    check("R1 irq/sleep", {13'b0, asleep, rxIrq, idleIrq}, 16'h0);

    // R9 no idle before any character
    ticks(200);
    check("R9 idle unarmed", 16'(idleFlag), 16'h0);

    // vector table: R2 data order and width, R3 noise, R4 framing
    for (int v = 0; v < 6; v++) begin
      nineBit = VEC[v][11];
      clearFlags();
      sendFrame(VEC[v][11], VEC[v][10:2], VEC[v][1], VEC[v][0]);
      ticks(2);
      check("R2 full", 16'(fullFlag), 16'h1);
      check("R2 data", 16'(rxData), VEC[v][11] ? 16'(VEC[v][10:2]) : 16'(VEC[v][9:2]));
      check("R3 noise", 16'(noiseFlag), 16'(VEC[v][1]));
      check("R4 framing", 16'(frameErrFlag), 16'(VEC[v][0]));
      check("R5 no overrun", 16'(overrunFlag), 16'h0);
    end
    nineBit = 1'b0;

    // R8 false start
    clearFlags();
    rxd = 1'b0;
    ticks(4);
    rxd = 1'b1;
    ticks(40);
    check("R8 false start", {14'b0, fullFlag, noiseFlag}, 16'h0);

    // R5 overrun, R7 receive interrupt, R6 clear handshake
    check("R7 irq off", 16'(rxIrq), 16'h0);
    sendFrame(1'b0, 9'h041, 1'b0, 1'b0);
    check("R7 irq masked", 16'(rxIrq), 16'h0);
    rieEn = 1'b1;
    @(negedge clk);
    check("R7 irq on", 16'(rxIrq), 16'h1);
    sendFrame(1'b0, 9'h042, 1'b0, 1'b0);
    ticks(1);
    check("R5 overrun", 16'(overrunFlag), 16'h1);
    check("R5 old data kept", 16'(rxData), 16'h041);
    pulse(dataRead);
    @(negedge clk);
    check("R6 lone data read", {14'b0, fullFlag, overrunFlag}, 16'h3);
    clearFlags();
    @(negedge clk);
    check("R6 cleared", {14'b0, fullFlag, overrunFlag}, 16'h0);
    check("R7 irq off after clear", 16'(rxIrq), 16'h0);
    rieEn = 1'b0;

    // R9/R10 idle detection
    ticks(200);
    clearFlags();
    ilieEn = 1'b1;
    ticks(200);
    check("R9 idle not rearmed", 16'(idleFlag), 16'h0);
    sendFrame(1'b0, 9'h035, 1'b0, 1'b0);
    ticks(130);
    check("R9 idle early", 16'(idleFlag), 16'h0);
    ticks(20);
    check("R9 idle set", 16'(idleFlag), 16'h1);
    check("R10 idle irq", 16'(idleIrq), 16'h1);
    clearFlags();
    ticks(200);
    check("R9 idle after clear", 16'(idleFlag), 16'h0);
    check("R10 idle irq off", 16'(idleIrq), 16'h0);
    ilieEn = 1'b0;

    // R11 wake on idle line
    wakeSel = 1'b0;
    pulse(wakeSet);
    @(negedge clk);
    check("R11 asleep", 16'(asleep), 16'h1);
    sendFrame(1'b0, 9'h035, 1'b0, 1'b0);
    ticks(1);
    check("R11 char ignored", {14'b0, fullFlag, asleep}, 16'h1);
    ticks(170);
    check("R11 woke", {14'b0, asleep, idleFlag}, 16'h0);

    // R12 wake on address
    wakeSel = 1'b1;
    pulse(wakeSet);
    sendFrame(1'b0, 9'h035, 1'b0, 1'b0);
    ticks(1);
    check("R12 non-address ignored", {14'b0, fullFlag, asleep}, 16'h1);
    sendFrame(1'b0, 9'h0B5, 1'b0, 1'b0);
    ticks(1);
    check("R12 address wakes", {14'b0, fullFlag, asleep}, 16'h2);
    check("R12 address data", 16'(rxData), 16'h0B5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule